// File: doc/BRIEF.md
# Fuse PROM Word Programming Sequencer

This block steers the programming of one word of a fuse-link PROM at a time. A start command brings in a target address and a mask of the bits to blow. The sequencer drives the address and holds chip select inactive. It asks an external supply switch to raise the supply to the programming level. It then strobes the pulse enable of each selected output line in turn, one at a time. When the last pulse is done it lowers the supply, activates chip select and reads the word back. An intact fuse reads high and a blown fuse must read low. Any selected bit that still reads high is reported, and the word is flagged as a reject.

The supply rise time, the settle delay and the pulse width are cycle counts. They are loaded by a configuration strobe while the block is idle and keep their reset defaults until then. A word whose mask is empty finishes at once, without raising the supply. The supply switch and the high-voltage pulse drivers sit outside this block.

Top module: `fuse_prog_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `reject`, `supplyHigh` and `pulseEn` are 0, and `chipSelN` is 1.
- R2: `promAddr` takes `wordAddr` when an operation starts and holds it for the whole operation. `chipSelN` stays 1 whenever `supplyHigh` or any `pulseEn` bit is 1.
- R3: A pulse enable is only ever active while `supplyHigh` is 1 and `chipSelN` is 1. No pulse is issued in the setup cycle that comes before the supply is raised.
- R4: After the setup cycle, `supplyHigh` is 1 for the rise count and then for the delay count before the first pulse begins. The first pulse starts in supply cycle rise+delay+1.
- R5: Each bit set in the mask gets exactly one pulse. A pulse lasts exactly the pulse count, at most one `pulseEn` bit is high at a time, and the pulses run in ascending bit order (bit 0 first). Bit i of `pulseEn` drives output line i.
- R6: Consecutive pulses are separated by exactly the delay count. After the last pulse, `supplyHigh` stays 1 for the delay count and then falls.
- R7: After the supply falls, `chipSelN` is 0 for exactly two cycles, and `verifyData` is sampled in the second of them. `failBits` equals mask AND readback. `reject` is 1 together with `done` when any `failBits` bit is set.
- R8: `busy` is 1 from the cycle after start until the cycle before the one-cycle `done` pulse. For k selected bits, `busy` lasts 1 + rise + k*(delay+pulse) + delay + 2 cycles.
- R9: An all-zero mask raises no supply, issues no pulse, never activates chip select, and gives `done` in the cycle after start with `reject` 0.
- R10: `cfgLoad` loads the rise, delay and pulse counts only while idle; a count of 0 acts as 1. The reset defaults are rise 4, delay 2 and pulse 4.
- R11: `start` and `cfgLoad` have no effect while `busy` is 1. The running operation keeps its address and timing, and no second operation follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | Load the three timing counts (idle only) |
| cfgRise | input | CNT_W | Supply rise time in cycles |
| cfgDelay | input | CNT_W | Settle and gap delay in cycles |
| cfgPulse | input | CNT_W | Programming pulse width in cycles |
| start | input | 1 | Begin programming one word |
| wordAddr | input | ADDR_W | Word to program |
| progMask | input | DATA_W | Bits to blow (1 = blow) |
| verifyData | input | DATA_W | Word read back from the PROM |
| promAddr | output | ADDR_W | Address driven to the PROM |
| chipSelN | output | 1 | Chip select, active low |
| supplyHigh | output | 1 | Request for the programming supply level |
| pulseEn | output | DATA_W | Per-output programming pulse enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| reject | output | 1 | Verify failure, valid with done |
| failBits | output | DATA_W | Selected bits that did not read back low |

## Verification
The assertions watch the safety rules on every cycle. They cover the single active pulse enable, pulses only under a raised supply with chip select high, and chip select going active only with the supply low and no pulse running. They also cover the address staying stable while busy, done lasting one cycle with busy low, and reject only appearing alongside done. The exact cycle counts of the rise, gap, pulse and tail windows can only be shown by the bench's scenarios, which measure them against a model PROM that has stuck fuses. The same goes for the ascending pulse order, the readback comparison, the zero-mask shortcut and the rejection of commands while busy.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_RISE, ST_GAP, ST_PULSE,
    ST_TAIL, ST_SETTLE, ST_SAMPLE, ST_FIN
  } seqState_t;

  typedef enum logic [1:0] {
    LD_RISE, LD_DELAY, LD_PULSE
  } cntSel_t;

  typedef struct packed {
    logic    latchOp;
    logic    loadCfg;
    logic    cntLoad;
    cntSel_t cntSel;
    logic    clearBit;
    logic    sampleVerify;
  } seqStrobe_t;

endpackage

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       cfgLoad,
  input  logic       maskZero,
  input  logic       cntZero,
  input  logic       lastBit,
  output seqStrobe_t stb,
  output logic       supplyHigh,
  output logic       chipSelN,
  output logic       busy,
  output logic       done,
  output logic       pulseActive
);

  seqState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    stb = '0;
    unique case (state)
      ST_IDLE: begin
        stb.loadCfg = cfgLoad;
        if (start) begin
          stb.latchOp = 1'b1;
          nxt = maskZero ? ST_FIN : ST_SETUP;
        end
      end
      ST_SETUP: begin
        stb.cntLoad = 1'b1;
        stb.cntSel  = LD_RISE;
        nxt = ST_RISE;
      end
      ST_RISE: if (cntZero) begin
        stb.cntLoad = 1'b1;
        stb.cntSel  = LD_DELAY;
        nxt = ST_GAP;
      end
      ST_GAP: if (cntZero) begin
        stb.cntLoad = 1'b1;
        stb.cntSel  = LD_PULSE;
        nxt = ST_PULSE;
      end
      ST_PULSE: if (cntZero) begin
        stb.clearBit = 1'b1;
        stb.cntLoad  = 1'b1;
        stb.cntSel   = LD_DELAY;
        nxt = lastBit ? ST_TAIL : ST_GAP;
      end
      ST_TAIL:   if (cntZero) nxt = ST_SETTLE;
      ST_SETTLE: nxt = ST_SAMPLE;
      ST_SAMPLE: begin
        stb.sampleVerify = 1'b1;
        nxt = ST_FIN;
      end
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign supplyHigh  = (state == ST_RISE) || (state == ST_GAP) ||
                       (state == ST_PULSE) || (state == ST_TAIL);
  assign chipSelN    = !((state == ST_SETTLE) || (state == ST_SAMPLE));
  assign busy        = (state != ST_IDLE) && (state != ST_FIN);
  assign done        = (state == ST_FIN);
  assign pulseActive = (state == ST_PULSE);

endmodule

// File: rtl/fps_datapath.sv
module fps_datapath
  import fps_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 8,
  parameter int DEF_RISE  = 4,
  parameter int DEF_DELAY = 2,
  parameter int DEF_PULSE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [CNT_W-1:0]  cfgRise,
  input  logic [CNT_W-1:0]  cfgDelay,
  input  logic [CNT_W-1:0]  cfgPulse,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [DATA_W-1:0] progMask,
  input  logic [DATA_W-1:0] verifyData,
  input  logic              pulseActive,
  output logic [ADDR_W-1:0] promAddr,
  output logic [DATA_W-1:0] pulseEn,
  output logic [DATA_W-1:0] failBits,
  output logic              cntZero,
  output logic              lastBit,
  output logic              maskZero
);

  localparam logic [CNT_W-1:0] RISE_RST  = CNT_W'(DEF_RISE);
  localparam logic [CNT_W-1:0] DELAY_RST = CNT_W'(DEF_DELAY);
  localparam logic [CNT_W-1:0] PULSE_RST = CNT_W'(DEF_PULSE);

  logic [CNT_W-1:0]  riseQ, delayQ, pulseQ, cnt, selCount, loadVal;
  logic [DATA_W-1:0] maskQ, remaining, curBit;

  // timing counts, taken only when the control strobes a load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseQ  <= RISE_RST;
      delayQ <= DELAY_RST;
      pulseQ <= PULSE_RST;
    end else if (stb.loadCfg) begin
      riseQ  <= cfgRise;
      delayQ <= cfgDelay;
      pulseQ <= cfgPulse;
    end
  end

  // one shared down-counter; a count of N keeps a state for N cycles
  always_comb begin
    unique case (stb.cntSel)
      LD_RISE:  selCount = riseQ;
      LD_DELAY: selCount = delayQ;
      LD_PULSE: selCount = pulseQ;
      default:  selCount = riseQ;
    endcase
    loadVal = (selCount == '0) ? '0 : selCount - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (stb.cntLoad)   cnt <= loadVal;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  // word registers and pending-bit set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      promAddr  <= '0;
      maskQ     <= '0;
      remaining <= '0;
      failBits  <= '0;
    end else begin
      if (stb.latchOp) begin
        promAddr  <= wordAddr;
        maskQ     <= progMask;
        remaining <= progMask;
        failBits  <= '0;
      end
      if (stb.clearBit)     remaining <= remaining & ~curBit;
      if (stb.sampleVerify) failBits  <= maskQ & verifyData;
    end
  end

  // lowest pending bit gives ascending pulse order
  assign curBit   = remaining & (~remaining + 1'b1);
  assign lastBit  = ((remaining & ~curBit) == '0);
  assign maskZero = (progMask == '0);
  assign pulseEn  = pulseActive ? curBit : '0;

endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
  import fps_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 8,
  parameter int DEF_RISE  = 4,
  parameter int DEF_DELAY = 2,
  parameter int DEF_PULSE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [CNT_W-1:0]  cfgRise,
  input  logic [CNT_W-1:0]  cfgDelay,
  input  logic [CNT_W-1:0]  cfgPulse,
  input  logic              start,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [DATA_W-1:0] progMask,
  input  logic [DATA_W-1:0] verifyData,
  output logic [ADDR_W-1:0] promAddr,
  output logic              chipSelN,
  output logic              supplyHigh,
  output logic [DATA_W-1:0] pulseEn,
  output logic              busy,
  output logic              done,
  output logic              reject,
  output logic [DATA_W-1:0] failBits
);

  seqStrobe_t stb;
  logic cntZero, lastBit, maskZero, pulseActive;

  fps_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgLoad(cfgLoad),
    .maskZero(maskZero), .cntZero(cntZero), .lastBit(lastBit),
    .stb(stb), .supplyHigh(supplyHigh), .chipSelN(chipSelN),
    .busy(busy), .done(done), .pulseActive(pulseActive)
  );

  fps_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .DEF_RISE(DEF_RISE), .DEF_DELAY(DEF_DELAY), .DEF_PULSE(DEF_PULSE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cfgRise(cfgRise), .cfgDelay(cfgDelay), .cfgPulse(cfgPulse),
    .wordAddr(wordAddr), .progMask(progMask), .verifyData(verifyData),
    .pulseActive(pulseActive), .promAddr(promAddr), .pulseEn(pulseEn),
    .failBits(failBits), .cntZero(cntZero), .lastBit(lastBit),
    .maskZero(maskZero)
  );

  assign reject = done && (failBits != '0);

endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] promAddr,
  input logic              chipSelN,
  input logic              supplyHigh,
  input logic [DATA_W-1:0] pulseEn,
  input logic              busy,
  input logic              done,
  input logic              reject
);

  assert_one_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pulseEn));

  assert_pulse_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pulseEn != '0) |-> (supplyHigh && chipSelN));

  assert_cs_high_prog_R2: assert property (@(posedge clk) disable iff (!rstN)
    supplyHigh |-> chipSelN);

  assert_verify_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !chipSelN |-> (!supplyHigh && (pulseEn == '0)));

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(promAddr));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy ##1 !done));

  assert_reject_with_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    reject |-> done);

  assert_tail_no_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(supplyHigh) |-> ($past(pulseEn) == '0));

endmodule

bind fuse_prog_seq fps_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .promAddr(promAddr), .chipSelN(chipSelN),
  .supplyHigh(supplyHigh), .pulseEn(pulseEn), .busy(busy), .done(done),
  .reject(reject)
);

// File: tb/fuse_prog_seq_tb.sv
module fuse_prog_seq_tb;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0, start = 1'b0;
  logic [CW-1:0] cfgRise = '0, cfgDelay = '0, cfgPulse = '0;
  logic [AW-1:0] wordAddr = '0;
  logic [DW-1:0] progMask = '0, verifyData;
  logic [AW-1:0] promAddr;
  logic chipSelN, supplyHigh, busy, done, reject;
  logic [DW-1:0] pulseEn, failBits;

  always #2.5 clk = ~clk;

  fuse_prog_seq u_dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgRise(cfgRise),
    .cfgDelay(cfgDelay), .cfgPulse(cfgPulse), .start(start),
    .wordAddr(wordAddr), .progMask(progMask), .verifyData(verifyData),
    .promAddr(promAddr), .chipSelN(chipSelN), .supplyHigh(supplyHigh),
    .pulseEn(pulseEn), .busy(busy), .done(done), .reject(reject),
    .failBits(failBits)
  );

  // model PROM: fuses start intact (1); a pulse under raised supply blows it
  logic [DW-1:0] mem [16];
  logic [DW-1:0] stuckBits = '0;
  initial for (int i = 0; i < 16; i++) mem[i] = '1;
  always @(posedge clk)
    if (supplyHigh && chipSelN && pulseEn != '0)
      mem[promAddr] <= mem[promAddr] & ~(pulseEn & ~stuckBits);
  assign verifyData = chipSelN ? '1 : mem[promAddr];

  int checks = 0, errors = 0;
  int expTr = 4, expTd = 2, expTp = 4;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bitPos(input logic [DW-1:0] v);
    for (int i = 0; i < DW; i++) if (v[i]) return i;
    return -1;
  endfunction

  // waveform monitor
  int supCnt, csLowCnt, pulseCnt, widthErr, orderErr, gapErr, leadErr;
  int width, gapCnt, lastIdx;
  logic [DW-1:0] prevPulse = '0;

  task automatic clearMon();
    supCnt = 0; csLowCnt = 0; pulseCnt = 0; widthErr = 0; orderErr = 0;
    gapErr = 0; leadErr = 0; width = 0; gapCnt = 0; lastIdx = -1;
  endtask

  always @(negedge clk) begin
    if (supplyHigh) supCnt++;
    if (!chipSelN) csLowCnt++;
    if ($countones(pulseEn) > 1) orderErr++;
    if (pulseEn != '0) begin
      if (prevPulse == '0) begin
        if (pulseCnt == 0) begin
          if (supCnt != expTr + expTd + 1) leadErr++;
        end else if (gapCnt != expTd) gapErr++;
        if (bitPos(pulseEn) <= lastIdx) orderErr++;
        lastIdx = bitPos(pulseEn);
        pulseCnt++;
        width = 1;
      end else width++;
    end else begin
      if (prevPulse != '0) begin
        if (width != expTp) widthErr++;
        gapCnt = 1;
      end else gapCnt++;
    end
    prevPulse = pulseEn;
  end

  // one word operation; kind 1 = cfgLoad mid-run, kind 2 = stray start mid-run
  task automatic doOp(input logic [AW-1:0] a, input logic [DW-1:0] m,
                      input logic [DW-1:0] stuck, input int kind);
    int cyc, k, tmo, expCyc;
    logic [DW-1:0] expMem, expFail;
    logic gotRej;
    logic [DW-1:0] gotFail;
    k = $countones(m);
    expMem  = mem[a] & ~(m & ~stuck);
    expFail = m & expMem;
    expCyc  = (k == 0) ? 0 : 1 + expTr + k * (expTd + expTp) + expTd + 2;
    @(negedge clk);
    clearMon();
    stuckBits = stuck; wordAddr = a; progMask = m; start = 1'b1;
    cyc = 0; tmo = 0;
    @(negedge clk);
    start = 1'b0;
    while (!done && tmo < 5000) begin
      if (busy) cyc++;
      if (cyc == 3 && kind == 1) begin
        cfgLoad = 1'b1; cfgRise = 7; cfgDelay = 7; cfgPulse = 7;
      end else if (cyc == 3 && kind == 2) begin
        start = 1'b1; wordAddr = 4'd11; progMask = 8'hFF;
      end else begin
        cfgLoad = 1'b0; start = 1'b0;
      end
      tmo++;
      @(negedge clk);
    end
    cfgLoad = 1'b0; start = 1'b0;
    if (tmo >= 5000) check("watchdog op", 0, 1);
    gotRej = reject; gotFail = failBits;
    check("R8 busy length", cyc, expCyc);
    check("R7 reject", int'(gotRej), int'(expFail != '0));
    check("R7 failBits", int'(gotFail), int'(expFail));
    check("R5 pulse count", pulseCnt, k);
    check("R5 pulse width", widthErr, 0);
    check("R5 order/overlap", orderErr, 0);
    check("R6 pulse gaps", gapErr, 0);
    check("R4 lead to first pulse", leadErr, 0);
    check(k == 0 ? "R9 no supply" : "R6 supply cycles", supCnt,
          k == 0 ? 0 : expTr + k * (expTd + expTp) + expTd);
    check("R7 chip select low cycles", csLowCnt, k == 0 ? 0 : 2);
    check("R5 fuse result", int'(mem[a]), int'(expMem));
    @(negedge clk);
    check("R8 done one cycle", int'({busy, done}), 0);
  endtask

  task automatic loadCfg(input int r, input int d, input int p);
    @(negedge clk);
    cfgLoad = 1'b1; cfgRise = CW'(r); cfgDelay = CW'(d); cfgPulse = CW'(p);
    @(negedge clk);
    cfgLoad = 1'b0;
    expTr = (r == 0) ? 1 : r;
    expTd = (d == 0) ? 1 : d;
    expTp = (p == 0) ? 1 : p;
  endtask

  // {addr, mask, stuck}
  localparam logic [19:0] VEC [7] = '{
    {4'd3,  8'h01, 8'h00},
    {4'd5,  8'hA5, 8'h00},
    {4'd9,  8'hFF, 8'h00},
    {4'd12, 8'h18, 8'h10},
    {4'd0,  8'h80, 8'h80},
    {4'd7,  8'h00, 8'h00},
    {4'd3,  8'h03, 8'h00}
  };

  initial begin
    clearMon();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 idle outputs", int'({busy, done, reject, supplyHigh}), 0);
    check("R1 pulseEn", int'(pulseEn), 0);
    check("R1 chipSelN", int'(chipSelN), 1);

    // vector table on reset-default timing (R10 defaults)
    for (int v = 0; v < 7; v++)
      doOp(VEC[v][19:16], VEC[v][15:8], VEC[v][7:0], 0);
    check("R2 address held", int'(promAddr), 3);

    // R10 zero counts act as one
    loadCfg(0, 0, 0);
    doOp(4'd1, 8'h03, 8'h00, 0);

    // R10/R11 cfgLoad while busy ignored: this and next run keep 3/2/4
    loadCfg(3, 2, 4);
    doOp(4'd2, 8'h01, 8'h00, 1);
    doOp(4'd2, 8'h40, 8'h00, 0);

    // R11 start while busy ignored: word 11 stays intact
    doOp(4'd10, 8'h01, 8'h00, 2);
    check("R11 stray word untouched", int'(mem[11]), 8'hFF);
    repeat (3) @(negedge clk);
    check("R11 no second run", int'(busy), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule